// File: doc/BRIEF.md
# Shadow Memory Replay Controller

This block keeps two byte-wide memories in step: a primary array used only by the CPU, and a shadow array read only by a video fetch engine. The video engine can read memory without stalling the CPU because the shadow copy is kept coherent by replaying work instead of by arbitration. Each CPU bus cycle ends on the falling edge of the bus clock. At that point the controller completes the CPU access to the primary array and latches the address and the byte that was transferred. On the next rising edge of the bus clock, the controller opens a short isolation window. During that window the video reader is cut off from the shadow array, and the latched address and byte are written into it.

The replay write happens on every bus cycle, whatever its direction. After a CPU read, the latched byte is the value just read from the primary array, so the shadow array keeps its value. A video request that arrives while the window is open is held, and it is served on the first fast-clock cycle after the window closes. The bus clock is asynchronous to the fast clock and passes through a synchronizer first. The array depth is a parameter. Setting `ADDR_W` to 16 gives the full 64K x 8 arrays.

Top module: `shadow_replay_ctrl`

## Requirements
- R1: While `rst_n` is low, `shadow_busy` and `vid_valid` are both 0.
- R2: On a CPU write (`cpu_we`=1 at the falling edge of `bus_clk`), the primary array stores `cpu_wdata` at `cpu_addr`. From the 4th fast-clock edge after that falling edge, `cpu_rdata` returns the new byte.
- R3: Each rising edge of `bus_clk` raises `shadow_busy` after the 3rd fast-clock edge. `shadow_busy` then stays high for exactly 2 fast-clock cycles.
- R4: After a CPU write cycle, the next isolation window writes the written byte into the shadow array at the same address.
- R5: After a CPU read cycle, the replay writes back the byte read from the primary array. It never writes `cpu_wdata`, so the shadow byte keeps its value.
- R6: A video request (`vid_req`=1 at an edge) that is sampled while `shadow_busy` is 0 produces `vid_valid`=1 for one cycle after that edge. At the same time, `vid_rdata` holds the shadow byte at `vid_addr`.
- R7: A video request sampled while `shadow_busy` is 1 is held. It is served on the first edge at which `shadow_busy` is 0 again, and it returns the shadow byte as it stands after the replay. `vid_valid` is never 1 in the cycle right after a cycle with `shadow_busy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | CPU bus clock, asynchronous to `clk` |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_rdata | output | 8 | Primary array byte at `cpu_addr` |
| vid_req | input | 1 | Video read request, one outstanding at most |
| vid_addr | input | ADDR_W | Video read address |
| vid_rdata | output | 8 | Video read byte |
| vid_valid | output | 1 | `vid_rdata` is valid this cycle |
| shadow_busy | output | 1 | Isolation window: shadow array owned by the replay write |

## Verification
The bench aims at a video request that lands exactly inside the isolation window. A design that failed to hold it would answer early with the pre-replay byte, or lose the request altogether. The bench replays read cycles while driving a garbage byte on `cpu_wdata`. A design that replayed the bus data instead of the read-back byte would corrupt the shadow copy. The window length is checked on every fast-clock edge, so a window that is one cycle short or one cycle long is reported. Overwrites of one address and the top address are included to catch stale latches and truncated address paths.

// File: rtl/shadow_replay_pkg.sv
package shadow_replay_pkg;
    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/bus_edge_detect.sv
module bus_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/replay_ram.sv
module replay_ram
    import shadow_replay_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/shadow_replay_ctrl.sv
module shadow_replay_ctrl
    import shadow_replay_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic [7:0]        cpu_rdata,
    input  logic              vid_req,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [7:0]        vid_rdata,
    output logic              vid_valid,
    output logic              shadow_busy
);
    localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYC - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] lat_addr;
        byte_t             lat_data;
        logic              pend;
        logic [ADDR_W-1:0] pend_addr;
        logic              vvalid;
        byte_t             vdata;
    } state_t;

    state_t st_d, st_q;

    logic              bus_rise, bus_fall;
    logic              prim_we, sh_we;
    byte_t             prim_rd, sh_rd;
    logic [ADDR_W-1:0] sh_raddr;

    bus_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_clk),
        .rise     (bus_rise),
        .fall     (bus_fall)
    );

    replay_ram #(.ADDR_W(ADDR_W)) u_primary (
        .clk   (clk),
        .we    (prim_we),
        .waddr (cpu_addr),
        .wdata (cpu_wdata),
        .raddr (cpu_addr),
        .rdata (prim_rd)
    );

    replay_ram #(.ADDR_W(ADDR_W)) u_shadow (
        .clk   (clk),
        .we    (sh_we),
        .waddr (st_q.lat_addr),
        .wdata (st_q.lat_data),
        .raddr (sh_raddr),
        .rdata (sh_rd)
    );

    assign sh_raddr = st_q.pend ? st_q.pend_addr : vid_addr;

    always_comb begin
        st_d      = st_q;
        prim_we   = 1'b0;
        sh_we     = 1'b0;
        st_d.vvalid = 1'b0;

        // End of CPU cycle: complete the primary access and latch it.
        if (bus_fall) begin
            prim_we       = cpu_we;
            st_d.lat_addr = cpu_addr;
            st_d.lat_data = cpu_we ? cpu_wdata : prim_rd;
        end

        // Isolation window and replay write.
        if (st_q.busy) begin
            sh_we = 1'b1;
            if (st_q.cnt == CNT_LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (bus_rise) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end

        // Video reads: served outside the window, held inside it.
        if (!st_q.busy && (st_q.pend || vid_req)) begin
            st_d.vvalid = 1'b1;
            st_d.vdata  = sh_rd;
            st_d.pend   = 1'b0;
        end else if (st_q.busy && vid_req && !st_q.pend) begin
            st_d.pend      = 1'b1;
            st_d.pend_addr = vid_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rdata   = prim_rd;
    assign vid_rdata   = st_q.vdata;
    assign vid_valid   = st_q.vvalid;
    assign shadow_busy = st_q.busy;
endmodule

// File: rtl/shadow_replay_chk.sv
module shadow_replay_chk (
    input logic clk,
    input logic rst_n,
    input logic shadow_busy,
    input logic vid_req,
    input logic vid_valid
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (!shadow_busy && !vid_valid));

    assert_window_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shadow_busy) |=> shadow_busy);

    assert_window_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_busy && $past(shadow_busy)) |=> !shadow_busy);

    assert_open_serve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_req && !shadow_busy) |=> vid_valid);

    assert_hold_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid |-> !$past(shadow_busy));
endmodule

bind shadow_replay_ctrl shadow_replay_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shadow_busy (shadow_busy),
    .vid_req     (vid_req),
    .vid_valid   (vid_valid)
);

// File: tb/tb_shadow_replay_ctrl.sv
module tb_shadow_replay_ctrl;
    localparam int AW   = 10;
    localparam int HALF = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_clk;
    logic [AW-1:0] cpu_addr;
    logic [7:0]    cpu_wdata;
    logic          cpu_we;
    logic [7:0]    cpu_rdata;
    logic          vid_req;
    logic [AW-1:0] vid_addr;
    logic [7:0]    vid_rdata;
    logic          vid_valid;
    logic          shadow_busy;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] prim_m [int];
    logic [7:0] sh_m [int];
    int         lat_a = 0;
    logic [7:0] lat_d = 8'h00;

    always #10 clk = ~clk;

    shadow_replay_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_rdata(cpu_rdata), .vid_req(vid_req), .vid_addr(vid_addr),
        .vid_rdata(vid_rdata), .vid_valid(vid_valid), .shadow_busy(shadow_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle: high phase (replays the previous latch), then low phase
    // ending the CPU access. vmode 1: request placed inside the window,
    // vmode 2: request in the open part of the high phase.
    task automatic bus_cycle(input int a, input logic [7:0] d, input bit we,
                             input int vmode, input int vaddr);
        bus_clk = 1'b1;
        for (int age = 1; age <= HALF; age++) begin
            bit exp_valid;
            @(negedge clk);
            chk(shadow_busy == (age == 3 || age == 4), "R3 window",
                shadow_busy, (age == 3 || age == 4));
            if (age == 4) sh_m[lat_a] = lat_d;
            exp_valid = (vmode == 1 && age == 6) || (vmode == 2 && age == 9);
            chk(vid_valid == exp_valid, (vmode == 1) ? "R7 held timing" : "R6 timing",
                vid_valid, exp_valid);
            if (exp_valid)
                chk(vid_rdata === sh_m[vaddr], (vmode == 1) ? "R4/R5/R7 data" : "R6 data",
                    vid_rdata, sh_m[vaddr]);
            if ((vmode == 1 && age == 3) || (vmode == 2 && age == 8)) begin
                vid_req  = 1'b1;
                vid_addr = AW'(vaddr);
            end else begin
                vid_req = 1'b0;
            end
        end
        cpu_addr  = AW'(a);
        cpu_we    = we;
        cpu_wdata = we ? d : 8'hEE;
        bus_clk   = 1'b0;
        for (int age = 1; age <= HALF; age++) begin
            @(negedge clk);
            chk(!shadow_busy && !vid_valid, "R3 quiet low phase",
                {shadow_busy, vid_valid}, 0);
            if (age == 3) begin
                if (we) prim_m[a] = d;
                lat_a = a;
                lat_d = prim_m[a];
            end
            if (age == 4) chk(cpu_rdata === prim_m[a], "R2 primary", cpu_rdata, prim_m[a]);
        end
    endtask

    initial begin
        rst_n = 1'b0; bus_clk = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        cpu_we = 1'b0; vid_req = 1'b0; vid_addr = '0;
        repeat (3) @(negedge clk);
        chk(!shadow_busy, "R1 busy", shadow_busy, 0);
        chk(!vid_valid, "R1 valid", vid_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_cycle(5,    8'h3C, 1, 0, 0);
        bus_cycle(9,    8'hA5, 1, 1, 5);    // R4, R7
        bus_cycle(5,    8'h00, 0, 1, 9);    // read cycle
        bus_cycle(1023, 8'h7E, 1, 1, 5);    // R5 replay of read
        bus_cycle(9,    8'h11, 1, 1, 1023); // top address
        bus_cycle(9,    8'h22, 1, 2, 9);    // R6
        bus_cycle(0,    8'h99, 1, 1, 9);    // overwrite
        bus_cycle(9,    8'h00, 0, 2, 0);    // R6
        bus_cycle(5,    8'h00, 0, 1, 9);    // R5
        bus_cycle(5,    8'h00, 0, 1, 5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule